// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO Controller

This block is a small first-in first-out buffer of sixteen 5-bit words. Its write and read sides are driven by slow external strobes, not by handshakes on the system clock. Two load strobes are combined so that either one clocks a word in while the other acts as a gate. An unload strobe, which rests high, pops the head word on its rising edge. Every strobe passes through a two-stage synchronizer on the single system clock, and edges are detected after the second stage.

Two flags report status. `in_ready` says that a slot is free. `out_ready` says that a valid word sits at the output and the unload strobe is high. An active-low unload-out pulse goes out whenever the input side can take another word. It can drive the unload strobe of an upstream buffer, which lets buffers be chained in depth. A clear strobe acts on its falling edge and empties the buffer. An output-enable input drives a separate data-valid signal that stands in for three-state drivers.

The head-state machine has four states:
- `HS_IDLE`: the strobe is high and there is no data.
- `HS_READY`: there is data and the strobe is high. This is the only state in which `out_ready` is high.
- `HS_TAKE`: the strobe fell while data was present, so the next rise pops.
- `HS_HOLD`: the strobe fell with no data present, so the next rise does not pop.

Its transitions are:
- IDLE→HOLD when the strobe falls.
- IDLE→READY when data appears.
- READY→TAKE when the strobe falls.
- TAKE→READY or TAKE→IDLE when the strobe rises, depending on whether data remains after the pop.
- HOLD→READY or HOLD→IDLE when the strobe rises, depending on whether data is present.
- Any state→IDLE on a clear while the strobe is high, or →HOLD on a clear while it is low.

Top module: `fifo_cascade_ctrl`

## Requirements
- R1: Words come out in the order they were written, unchanged in value, over the full 5-bit range including 5'h10 and 5'h1F.
- R2: A rising edge of one load strobe writes a word only while the other load strobe is high. With the gate strobe low, toggling the other strobe writes nothing.
- R3: The two load strobes are interchangeable: a word clocked by `ld_b`, with `ld_a` as the gate, is stored like one clocked by `ld_a`.
- R4: A rising edge of `unload_in` after it fell while `out_ready` was high removes the head word, and the next word appears on `dout`.
- R5: `in_ready` is high exactly while fewer than 16 words are held. A write made while it is low is discarded.
- R6: `out_ready` is high only while a word is at the head and the synchronized unload strobe is high. It goes low after a falling edge of the strobe and stays low until the strobe is high again with a word present.
- R7: An unload cycle whose falling edge came while `out_ready` was low removes nothing, even if a word arrives while the strobe is low.
- R8: `unload_out_n` goes low for `PULSE_LEN` (default 3) clock cycles after an accepted write that leaves a slot free, or after a read from a full buffer. Otherwise it stays high, including after the write that fills the buffer.
- R9: A falling edge of `clr_n` discards all words: `out_ready` goes low and `in_ready` goes high. A later write is the new head.
- R10: `dout_en` is low while `oe_n` is high. `out_ready` and `dout` are not affected by `oe_n`.
- R11: A write and a read that take effect in the same cycle leave the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ld_a | input | 1 | Load strobe A (clock or gate) |
| ld_b | input | 1 | Load strobe B (clock or gate) |
| din | input | 5 | Write data |
| unload_in | input | 1 | Unload strobe, rests high, pops on rising edge |
| clr_n | input | 1 | Clear strobe, acts on falling edge |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 5 | Head word |
| dout_en | output | 1 | High when `dout` is driven (low models high impedance) |
| in_ready | output | 1 | A slot is free |
| out_ready | output | 1 | Head word valid and unload strobe high |
| unload_out_n | output | 1 | Low pulse requesting a word from an upstream stage |

## Verification
A wrong occupancy count shows in two ways. `in_ready` drops after the wrong number of writes, and a wrong count also shifts the unload-out pulse pattern. Both become visible at the write that crosses sixteen, three edges after that strobe rises. A head-state machine in the wrong state shows up immediately. It either raises `out_ready` while the strobe is low, or it pops a word on a stray unload cycle, which puts a skipped word on `dout` one strobe later. A pointer error stays hidden until the word it affects reaches the head, so the bench drains every fill completely and compares each word in order.

// File: rtl/fifo_cc_pkg.sv
`timescale 1ns/1ps
package fifo_cc_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_READY,
        HS_TAKE,
        HS_HOLD
    } head_state_e;

    localparam int STROBE_BITS = 4;
    localparam int SB_LD_A     = 0;
    localparam int SB_LD_B     = 1;
    localparam int SB_UNLOAD   = 2;
    localparam int SB_CLEAR    = 3;

endpackage

// File: rtl/fifo_cc_sync.sv
`timescale 1ns/1ps
module fifo_cc_sync #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] dly
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;
    logic [WIDTH-1:0] stage3;

    // one synchronizer chain per strobe; each bit rests at its idle level
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= RST_VAL[g];
                stage2[g] <= RST_VAL[g];
                stage3[g] <= RST_VAL[g];
            end else begin
                stage1[g] <= async_in[g];
                stage2[g] <= stage1[g];
                stage3[g] <= stage2[g];
            end
        end
    end

    assign lvl = stage2;
    assign dly = stage3;

endmodule

// File: rtl/fifo_cc_store.sv
`timescale 1ns/1ps
module fifo_cc_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_req,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             in_ready,
    output logic             head_valid,
    output logic             more_after_pop,
    output logic             last_vac
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE_PTR  = PTR_W'(1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_nxt;
    logic             wr_acc;
    logic             rd_acc;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + ONE_PTR;
    endfunction

    assign wr_acc = wr_req && (count != FULL_CNT) && !clear;
    assign rd_acc = pop && (count != '0) && !clear;

    always_comb begin
        count_nxt = count;
        if (wr_acc && !rd_acc) begin
            count_nxt = count + ONE_CNT;
        end else if (rd_acc && !wr_acc) begin
            count_nxt = count - ONE_CNT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_acc) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_acc) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem[wr_ptr] <= din;
        end
    end

    assign dout           = mem[rd_ptr];
    assign in_ready       = (count != FULL_CNT);
    assign head_valid     = (count != '0);
    assign more_after_pop = (count > ONE_CNT) || wr_acc;
    // input side can take another word: after a write with room left, or a read from full
    assign last_vac       = (wr_acc && (count_nxt != FULL_CNT)) ||
                            (rd_acc && (count == FULL_CNT));

endmodule

// File: rtl/fifo_cc_head_fsm.sv
`timescale 1ns/1ps
module fifo_cc_head_fsm
    import fifo_cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strobe_lvl,
    input  logic strobe_rise,
    input  logic strobe_fall,
    input  logic head_valid,
    input  logic more_after_pop,
    output logic pop,
    output logic out_ready
);

    head_state_e state;
    head_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (clear) begin
            state_nxt = strobe_lvl ? HS_IDLE : HS_HOLD;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (strobe_fall) begin
                        state_nxt = HS_HOLD;
                    end else if (head_valid) begin
                        state_nxt = HS_READY;
                    end
                end
                HS_READY: begin
                    if (strobe_fall) begin
                        state_nxt = HS_TAKE;
                    end
                end
                HS_TAKE: begin
                    if (strobe_rise) begin
                        state_nxt = more_after_pop ? HS_READY : HS_IDLE;
                    end
                end
                HS_HOLD: begin
                    if (strobe_rise) begin
                        state_nxt = head_valid ? HS_READY : HS_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        out_ready = (state == HS_READY);
        pop       = (state == HS_TAKE) && strobe_rise && !clear;
    end

endmodule

// File: rtl/fifo_cc_pulse.sv
`timescale 1ns/1ps
module fifo_cc_pulse #(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse_n
);

    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_LEN);
    localparam logic [CW-1:0] ONE_VAL  = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (trigger) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - ONE_VAL;
        end
    end

    assign pulse_n = (remain == '0);

endmodule

// File: rtl/fifo_cascade_ctrl.sv
`timescale 1ns/1ps
module fifo_cascade_ctrl
    import fifo_cc_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WIDTH     = 5,
    parameter int PULSE_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_a,
    input  logic             ld_b,
    input  logic [WIDTH-1:0] din,
    input  logic             unload_in,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             in_ready,
    output logic             out_ready,
    output logic             unload_out_n
);

    logic [STROBE_BITS-1:0] s_lvl;
    logic [STROBE_BITS-1:0] s_dly;
    logic [STROBE_BITS-1:0] s_raw;
    logic                   wr_req;
    logic                   unl_lvl;
    logic                   unl_rise;
    logic                   unl_fall;
    logic                   clr_evt;
    logic                   pop;
    logic                   head_valid;
    logic                   more_after_pop;
    logic                   last_vac;

    always_comb begin
        s_raw            = '1;
        s_raw[SB_LD_A]   = ld_a;
        s_raw[SB_LD_B]   = ld_b;
        s_raw[SB_UNLOAD] = unload_in;
        s_raw[SB_CLEAR]  = clr_n;
    end

    fifo_cc_sync #(
        .WIDTH   (STROBE_BITS),
        .RST_VAL ({STROBE_BITS{1'b1}})
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (s_raw),
        .lvl      (s_lvl),
        .dly      (s_dly)
    );

    // either strobe clocks, the other gates
    assign wr_req   = (s_lvl[SB_LD_A] & ~s_dly[SB_LD_A] & s_lvl[SB_LD_B]) |
                      (s_lvl[SB_LD_B] & ~s_dly[SB_LD_B] & s_lvl[SB_LD_A]);
    assign unl_lvl  = s_lvl[SB_UNLOAD];
    assign unl_rise = s_lvl[SB_UNLOAD] & ~s_dly[SB_UNLOAD];
    assign unl_fall = ~s_lvl[SB_UNLOAD] & s_dly[SB_UNLOAD];
    assign clr_evt  = ~s_lvl[SB_CLEAR] & s_dly[SB_CLEAR];

    fifo_cc_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) store_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (clr_evt),
        .wr_req         (wr_req),
        .pop            (pop),
        .din            (din),
        .dout           (dout),
        .in_ready       (in_ready),
        .head_valid     (head_valid),
        .more_after_pop (more_after_pop),
        .last_vac       (last_vac)
    );

    fifo_cc_head_fsm head_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (clr_evt),
        .strobe_lvl     (unl_lvl),
        .strobe_rise    (unl_rise),
        .strobe_fall    (unl_fall),
        .head_valid     (head_valid),
        .more_after_pop (more_after_pop),
        .pop            (pop),
        .out_ready      (out_ready)
    );

    fifo_cc_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (last_vac),
        .pulse_n (unload_out_n)
    );

    assign dout_en = ~oe_n;

endmodule

// File: rtl/fifo_cc_checker.sv
`timescale 1ns/1ps
module fifo_cc_checker (
    input logic clk,
    input logic rst_n,
    input logic unl_lvl,
    input logic unl_fall,
    input logic clr_evt,
    input logic pop,
    input logic in_ready,
    input logic out_ready,
    input logic unload_out_n,
    input logic last_vac
);

    AST_OR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !unl_fall) |-> unl_lvl); // R6

    AST_FALL_DROPS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        unl_fall |=> !out_ready); // R6

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !pop && !clr_evt) |=> !in_ready); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (in_ready && !out_ready)); // R9

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unload_out_n) |-> $past(last_vac)); // R8

    AST_NO_POP_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !out_ready); // R7

endmodule

bind fifo_cascade_ctrl fifo_cc_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .unl_lvl      (unl_lvl),
    .unl_fall     (unl_fall),
    .clr_evt      (clr_evt),
    .pop          (pop),
    .in_ready     (in_ready),
    .out_ready    (out_ready),
    .unload_out_n (unload_out_n),
    .last_vac     (last_vac)
);

// File: tb/fifo_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_cascade_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_a = 1'b0;
    logic       ld_b = 1'b1;
    logic [4:0] din = '0;
    logic       unload_in = 1'b1;
    logic       clr_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [4:0] dout;
    logic       dout_en;
    logic       in_ready;
    logic       out_ready;
    logic       unload_out_n;

    int n_chk = 0;
    int n_err = 0;
    int pulse_total = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    fifo_cascade_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_a         (ld_a),
        .ld_b         (ld_b),
        .din          (din),
        .unload_in    (unload_in),
        .clr_n        (clr_n),
        .oe_n         (oe_n),
        .dout         (dout),
        .dout_en      (dout_en),
        .in_ready     (in_ready),
        .out_ready    (out_ready),
        .unload_out_n (unload_out_n)
    );

    always @(negedge clk) begin
        if (rst_n && !unload_out_n) pulse_total++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // rest state: ld_a low, ld_b high
    task automatic write_a(input logic [4:0] d);
        din = d;
        ld_a = 1'b1;
        wait_n(6);
        ld_a = 1'b0;
        wait_n(6);
    endtask

    task automatic write_b(input logic [4:0] d);
        din = d;
        ld_b = 1'b0;
        wait_n(6);
        ld_a = 1'b1;
        wait_n(6);
        ld_b = 1'b1;
        wait_n(6);
        ld_a = 1'b0;
        wait_n(6);
    endtask

    task automatic read_one(input string req);
        unload_in = 1'b0;
        wait_n(6);
        chk(req, out_ready, 0);
        unload_in = 1'b1;
        wait_n(6);
    endtask

    task automatic t_reset;
        chk("R5 in_ready after reset", in_ready, 1);
        chk("R6 out_ready after reset", out_ready, 0);
        chk("R8 unload_out_n after reset", unload_out_n, 1);
        chk("R10 dout_en with oe_n low", dout_en, 1);
    endtask

    task automatic t_gate_closed;
        int p0 = pulse_total;
        ld_b = 1'b0;
        wait_n(6);
        ld_a = 1'b1;
        wait_n(6);
        ld_a = 1'b0;
        wait_n(6);
        ld_b = 1'b1;
        wait_n(6);
        chk("R2 gated write absent", out_ready, 0);
        chk("R2 no pulse on gated strobe", pulse_total - p0, 0);
    endtask

    task automatic t_basic_order;
        write_a(5'h11);
        write_a(5'h0A);
        write_a(5'h1F);
        chk("R6 out_ready with data", out_ready, 1);
        chk("R1 first word", dout, 5'h11);
        read_one("R6 out_ready low while strobe low");
        chk("R4 second word after pop", dout, 5'h0A);
        chk("R4 out_ready back high", out_ready, 1);
        read_one("R6 low on second read");
        chk("R1 third word", dout, 5'h1F);
        read_one("R6 low on third read");
        chk("R4 empty after last pop", out_ready, 0);
    endtask

    task automatic t_interchange;
        write_b(5'h05);
        chk("R3 word clocked by ld_b present", out_ready, 1);
        chk("R3 word clocked by ld_b value", dout, 5'h05);
        read_one("R3 read");
        chk("R3 empty after read", out_ready, 0);
    endtask

    task automatic t_hold_no_pop;
        unload_in = 1'b0;
        wait_n(6);
        write_a(5'h16);
        chk("R7 out_ready low while strobe low", out_ready, 0);
        unload_in = 1'b1;
        wait_n(6);
        chk("R7 word kept after empty unload", out_ready, 1);
        chk("R7 word value kept", dout, 5'h16);
        read_one("R7 read");
        chk("R7 empty", out_ready, 0);
    endtask

    task automatic t_full_and_pulse;
        int p0;
        for (int k = 0; k < 16; k++) begin
            p0 = pulse_total;
            write_a(5'(k + 1));
            if (k == 0) chk("R8 pulse after write with room", pulse_total - p0, 3);
            if (k == 14) begin
                chk("R8 pulse at fifteenth write", pulse_total - p0, 3);
                chk("R5 in_ready at 15 words", in_ready, 1);
            end
            if (k == 15) begin
                chk("R8 no pulse when filled", pulse_total - p0, 0);
                chk("R5 in_ready low when full", in_ready, 0);
            end
        end
        p0 = pulse_total;
        write_a(5'h1E);
        chk("R5 no pulse on discarded write", pulse_total - p0, 0);
        p0 = pulse_total;
        read_one("R6 read from full");
        chk("R8 pulse after read from full", pulse_total - p0, 3);
        chk("R5 in_ready after read from full", in_ready, 1);
        chk("R1 second word of fill", dout, 2);
        p0 = pulse_total;
        read_one("R6 read not from full");
        chk("R8 no pulse on read not from full", pulse_total - p0, 0);
        for (int k = 2; k < 16; k++) begin
            chk("R1 fill order", dout, k + 1);
            read_one("R6 drain");
        end
        chk("R5 discarded write absent", out_ready, 0);
    endtask

    task automatic t_simultaneous;
        write_a(5'h03);
        write_a(5'h04);
        unload_in = 1'b0;
        wait_n(6);
        din = 5'h07;
        unload_in = 1'b1;
        ld_a = 1'b1;
        wait_n(6);
        ld_a = 1'b0;
        wait_n(6);
        chk("R11 head after same-cycle pop", dout, 5'h04);
        for (int k = 0; k < 13; k++) write_a(5'(8 + k));
        chk("R11 in_ready at 15 words", in_ready, 1);
        write_a(5'h15);
        chk("R11 in_ready low at 16 words", in_ready, 0);
        chk("R11 drain word 0", dout, 5'h04);
        read_one("R6 drain");
        chk("R11 drain word 1", dout, 5'h07);
        read_one("R6 drain");
        for (int k = 0; k < 14; k++) begin
            chk("R11 drain tail", dout, 8 + k);
            read_one("R6 drain");
        end
        chk("R11 empty after drain", out_ready, 0);
    endtask

    task automatic t_output_enable;
        write_a(5'h09);
        oe_n = 1'b1;
        wait_n(3);
        chk("R10 dout_en low", dout_en, 0);
        chk("R10 out_ready unaffected", out_ready, 1);
        chk("R10 dout unaffected", dout, 5'h09);
        oe_n = 1'b0;
        wait_n(3);
        chk("R10 dout_en restored", dout_en, 1);
        read_one("R10 read");
    endtask

    task automatic t_clear;
        write_a(5'h0C);
        write_a(5'h0D);
        clr_n = 1'b0;
        wait_n(6);
        chk("R9 out_ready after clear", out_ready, 0);
        chk("R9 in_ready after clear", in_ready, 1);
        clr_n = 1'b1;
        wait_n(6);
        write_a(5'h02);
        chk("R9 new word is head", dout, 5'h02);
        chk("R9 out_ready after new word", out_ready, 1);
        read_one("R9 read");
        chk("R9 old words gone", out_ready, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(6);
        t_reset();
        t_gate_closed();
        t_basic_order();
        t_interchange();
        t_hold_no_pop();
        t_full_and_pulse();
        t_simultaneous();
        t_output_enable();
        t_clear();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule